// File: doc/BRIEF.md
# Race-to-Eight Frequency Comparator

This block decides which of two digital signals runs at the higher frequency by racing two decimal counters from a common starting point. Each channel takes an asynchronous input, brings it into the system clock domain, and counts its rising edges as BCD digits. The channel whose count gets to eight first raises its winner flag. Both counters then freeze, so the slower channel keeps the count it had reached at that moment.

If both channels get to eight on the same system clock edge, the result is a tie and both flags rise together. A start request clears both counts and both flags and sets the race running again. A start that arrives during a race restarts that race from zero. Each count also drives its own active-low seven-segment pattern. A count of zero is shown as the digit and is never blanked.

Top module: `freq_race_cmp`

## Requirements
- R1: While reset is asserted, and after it is released, both counts read 0, both winner flags are low, and both segment buses show the digit 0 (7'b1000000).
- R2: During a race, each rising edge of a channel's input adds one to that channel's BCD count (8421 weighting). The increment appears on the third rising clock edge after the input goes high, with the default two synchronizer stages.
- R3: A start request sampled high on a clock edge sets both counts to 0 and both flags low on that edge. Input edges that arrive in that cycle are not counted. Counting begins with the following edge.
- R4: The first channel to reach a count of 8 raises its winner flag on the same clock edge its count becomes 8. The flag stays high until the next start request.
- R5: Once any winner flag is high, neither count changes until a start request, whatever the inputs do.
- R6: If both channels reach 8 on the same clock edge, both flags rise together and both counts read 8.
- R7: A start request during a race returns both counts to 0 and begins a new race.
- R8: Each segment bus is active-low, with bit 0 = segment a through bit 6 = segment g. For each digit 0 to 9 the lit segments are: 0 abcdef, 1 bc, 2 abdeg, 3 abcdg, 4 bcfg, 5 acdfg, 6 acdefg, 7 abc, 8 abcdefg, 9 abcdfg.
- R9: A count never exceeds 8. A winner flag is high only while its own count reads 8.
- R10: After reset and before the first start request, input edges leave both counts at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_a | input | 1 | Asynchronous input signal, channel A |
| freq_b | input | 1 | Asynchronous input signal, channel B |
| start | input | 1 | Clears and begins a race, sampled on the clock edge |
| win_a | output | 1 | Channel A reached the threshold first (or tied) |
| win_b | output | 1 | Channel B reached the threshold first (or tied) |
| bcd_a | output | 4 | BCD count, channel A |
| bcd_b | output | 4 | BCD count, channel B |
| seg_a_n | output | 7 | Active-low segments for channel A, bit 0 = a |
| seg_b_n | output | 7 | Active-low segments for channel B, bit 0 = a |

## Verification
An input rise shows up in its count on the third clock edge after it. A winner flag changes on the same edge as the count that reaches eight, and a start request acts on the edge that samples it. The segment buses follow the counts with no further delay. The bench drives inputs 3 ns after each rising edge and keeps a queue of past input samples. It uses that queue to shift each edge by the same three-edge latency in its reference model, then compares every output at the falling edge. At that point all registers that answer to a given stimulus have already updated.

// File: rtl/freq_race_pkg.sv
package freq_race_pkg;
   localparam int BCD_W = 4;
   localparam int SEG_W = 7;

   typedef logic [BCD_W-1:0] bcd_t;
   typedef logic [SEG_W-1:0] seg_t;

   // active-high segment pattern, bit 0 = a ... bit 6 = g
   function automatic seg_t bcd_to_seg_hi(input bcd_t d);
      seg_t s;
      case (d)
         4'd0:    s = 7'b0111111;
         4'd1:    s = 7'b0000110;
         4'd2:    s = 7'b1011011;
         4'd3:    s = 7'b1001111;
         4'd4:    s = 7'b1100110;
         4'd5:    s = 7'b1101101;
         4'd6:    s = 7'b1111101;
         4'd7:    s = 7'b0000111;
         4'd8:    s = 7'b1111111;
         4'd9:    s = 7'b1101111;
         default: s = 7'b0000000;
      endcase
      return s;
   endfunction
endpackage

// File: rtl/fr_edge_sync.sv
module fr_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic rise
);
   localparam int PW = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("fr_edge_sync: STAGES must be at least 2");
   end

   // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
   logic [PW-1:0] pipe;

   always_ff @(posedge clk) begin
      if (rst) pipe <= '0;
      else     pipe <= {pipe[PW-2:0], din};
   end

   assign rise = pipe[STAGES-1] & ~pipe[STAGES];

   // R2: a detected rise is a single-cycle event
   a_r2_rise_pulse: assert property (@(posedge clk) disable iff (rst)
      rise |=> !rise);
endmodule

// File: rtl/fr_bcd_counter.sv
module fr_bcd_counter
   import freq_race_pkg::*;
#(
   parameter int MAX = 9
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic inc,
   output bcd_t q
);
   if (MAX < 1 || MAX > 9) begin : g_bad_max
      $error("fr_bcd_counter: MAX must lie in 1..9");
   end

   always_ff @(posedge clk) begin
      if (rst || clr)    q <= '0;
      else if (inc)      q <= (q == bcd_t'(MAX)) ? '0 : bcd_t'(q + 1'b1);
   end

   // R3: a clear leaves the count at zero
   a_r3_clear_zero: assert property (@(posedge clk) disable iff (rst)
      clr |=> (q == '0));
   // R5: without clear or increment the count holds
   a_r5_hold: assert property (@(posedge clk) disable iff (rst)
      (!clr && !inc) |=> $stable(q));
   // R2: the count stays a valid BCD digit
   a_r2_bcd_digit: assert property (@(posedge clk) disable iff (rst)
      q <= bcd_t'(MAX));
endmodule

// File: rtl/fr_seg_decode.sv
module fr_seg_decode
   import freq_race_pkg::*;
#(
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  bcd_t d,
   output seg_t seg
);
   seg_t lit;
   assign lit = bcd_to_seg_hi(d);

   if (ACTIVE_LOW) begin : g_low
      assign seg = ~lit;
   end else begin : g_high
      assign seg = lit;
   end
endmodule

// File: rtl/freq_race_cmp.sv
module freq_race_cmp
   import freq_race_pkg::*;
#(
   parameter int SYNC_STAGES    = 2,
   parameter int THRESH         = 8,
   parameter bit SEG_ACTIVE_LOW = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       freq_a,
   input  logic       freq_b,
   input  logic       start,
   output logic       win_a,
   output logic       win_b,
   output logic [3:0] bcd_a,
   output logic [3:0] bcd_b,
   output logic [6:0] seg_a_n,
   output logic [6:0] seg_b_n
);
   localparam int   NCH     = 2;
   localparam bcd_t LAST_PRE = bcd_t'(THRESH - 1);

   if (THRESH < 1 || THRESH > 9) begin : g_bad_thresh
      $error("freq_race_cmp: THRESH must lie in 1..9");
   end

   logic [NCH-1:0] fin, rise, inc, hit, win_q;
   logic           run_q;
   bcd_t           cnt [NCH];
   seg_t           seg [NCH];

   assign fin = {freq_b, freq_a};

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      fr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk (clk), .rst (rst), .din (fin[ch]), .rise (rise[ch])
      );

      assign inc[ch] = run_q & rise[ch] & ~start;

      fr_bcd_counter #(.MAX(9)) u_cnt (
         .clk (clk), .rst (rst), .clr (start), .inc (inc[ch]), .q (cnt[ch])
      );

      fr_seg_decode #(.ACTIVE_LOW(SEG_ACTIVE_LOW)) u_seg (
         .d (cnt[ch]), .seg (seg[ch])
      );

      // threshold detect: the event is the count about to reach THRESH
      if (THRESH == 8) begin : g_msb
         assign hit[ch] = inc[ch] & ~cnt[ch][3] & (&cnt[ch][2:0]);
      end else begin : g_cmp
         assign hit[ch] = inc[ch] & (cnt[ch] == LAST_PRE);
      end

      // R4: a winner flag persists until a new start
      a_r4_flag_sticky: assert property (@(posedge clk) disable iff (rst)
         (win_q[ch] && !start) |=> win_q[ch]);
      // R9: a flag implies its own count sits at the threshold
      a_r9_flag_count: assert property (@(posedge clk) disable iff (rst)
         win_q[ch] |-> (cnt[ch] == bcd_t'(THRESH)));
      // R9: counts never pass the threshold
      a_r9_limit: assert property (@(posedge clk) disable iff (rst)
         cnt[ch] <= bcd_t'(THRESH));
      // R5: both counts freeze once a winner exists
      a_r5_freeze: assert property (@(posedge clk) disable iff (rst)
         ((|win_q) && !start) |=> $stable(cnt[ch]));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         win_q <= '0;
         run_q <= 1'b0;
      end else if (start) begin
         win_q <= '0;
         run_q <= 1'b1;
      end else if (|hit) begin
         win_q <= win_q | hit;
         run_q <= 1'b0;
      end
   end

   // R3: start clears both flags
   a_r3_flags_clear: assert property (@(posedge clk) disable iff (rst)
      start |=> (win_q == '0));
   // R6: both counts at threshold means a reported tie
   a_r6_tie: assert property (@(posedge clk) disable iff (rst)
      ((cnt[0] == bcd_t'(THRESH)) && (cnt[1] == bcd_t'(THRESH))) |-> (&win_q));

   assign win_a   = win_q[0];
   assign win_b   = win_q[1];
   assign bcd_a   = cnt[0];
   assign bcd_b   = cnt[1];
   assign seg_a_n = seg[0];
   assign seg_b_n = seg[1];
endmodule

// File: tb/freq_race_cmp_test.sv
module freq_race_cmp_test;
   localparam int LAT = 2;   // synchronizer stages of the default build

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       fa = 1'b0, fb = 1'b0, start = 1'b0;
   logic       win_a, win_b;
   logic [3:0] bcd_a, bcd_b;
   logic [6:0] seg_a_n, seg_b_n;

   int n_chk = 0, n_bad = 0;
   bit cmp_on = 0;

   freq_race_cmp uut (
      .clk(clk), .rst(rst), .freq_a(fa), .freq_b(fb), .start(start),
      .win_a(win_a), .win_b(win_b), .bcd_a(bcd_a), .bcd_b(bcd_b),
      .seg_a_n(seg_a_n), .seg_b_n(seg_b_n)
   );

   always #10 clk = ~clk;

   task automatic chk(input string req, input bit ok, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [6:0] exp_seg(input int d);
      string s;
      logic [6:0] m = 7'h7f;
      case (d)
         0: s = "abcdef";  1: s = "bc";     2: s = "abdeg";   3: s = "abcdg";
         4: s = "bcfg";    5: s = "acdfg";  6: s = "acdefg";  7: s = "abc";
         8: s = "abcdefg"; 9: s = "abcdfg"; default: s = "";
      endcase
      for (int i = 0; i < s.len(); i++) m[s[i] - 8'd97] = 1'b0;
      return m;
   endfunction

   // reference model
   bit qa[$], qb[$];
   int mc[2];
   bit mw[2];
   bit mrun;

   always @(posedge clk) begin
      bit ra, rb, ha, hb;
      qa.push_front(rst ? 1'b0 : fa);
      qb.push_front(rst ? 1'b0 : fb);
      while (qa.size() < LAT + 2) qa.push_back(1'b0);
      while (qb.size() < LAT + 2) qb.push_back(1'b0);
      if (qa.size() > LAT + 2) void'(qa.pop_back());
      if (qb.size() > LAT + 2) void'(qb.pop_back());
      ra = qa[LAT] & ~qa[LAT+1];
      rb = qb[LAT] & ~qb[LAT+1];
      if (rst) begin
         mc = '{0, 0}; mw = '{0, 0}; mrun = 0;
      end else if (start) begin
         mc = '{0, 0}; mw = '{0, 0}; mrun = 1;
      end else if (mrun) begin
         ha = 0; hb = 0;
         if (ra) begin mc[0]++; ha = (mc[0] == 8); end
         if (rb) begin mc[1]++; hb = (mc[1] == 8); end
         if (ha || hb) begin
            mw[0] = mw[0] | ha; mw[1] = mw[1] | hb; mrun = 0;
         end
      end
      cmp_on <= 1'b1;
   end

   always @(negedge clk) begin
      if (cmp_on) begin
         chk("R2 count a", bcd_a == mc[0], bcd_a, mc[0]);
         chk("R2 count b", bcd_b == mc[1], bcd_b, mc[1]);
         chk("R4 flag a",  win_a == mw[0], win_a, mw[0]);
         chk("R4 flag b",  win_b == mw[1], win_b, mw[1]);
         chk("R8 seg a",   seg_a_n == exp_seg(mc[0]), seg_a_n, exp_seg(mc[0]));
         chk("R8 seg b",   seg_b_n == exp_seg(mc[1]), seg_b_n, exp_seg(mc[1]));
         chk("R9 limit",   (bcd_a <= 8) && (bcd_b <= 8), bcd_a * 16 + bcd_b, 8);
      end
   end

   task automatic tick();
      @(posedge clk); #3;
   endtask

   task automatic run(input int ha, input int hb, input int n);
      int pa = 0, pb = 0;
      repeat (n) begin
         tick();
         pa++; pb++;
         if (pa >= ha) begin pa = 0; fa = ~fa; end
         if (pb >= hb) begin pb = 0; fb = ~fb; end
      end
   endtask

   task automatic pulse_start();
      tick(); start = 1'b1;
      tick(); start = 1'b0;
   endtask

   initial begin
      #(20 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int hold_b;
      repeat (4) tick();
      // R1: reset state
      chk("R1 reset counts", bcd_a == 0 && bcd_b == 0, bcd_a + bcd_b, 0);
      chk("R1 reset flags", win_a == 0 && win_b == 0, win_a + win_b, 0);
      chk("R1 reset seg", seg_a_n == 7'b1000000 && seg_b_n == 7'b1000000, seg_a_n, 7'b1000000);
      rst = 1'b0;
      tick();
      chk("R1 after release", bcd_a == 0 && !win_a, bcd_a, 0);

      // R10: edges before any start are ignored
      run(2, 3, 40);
      chk("R10 idle a", bcd_a == 0, bcd_a, 0);
      chk("R10 idle b", bcd_b == 0, bcd_b, 0);

      // R3 and R4: A faster
      pulse_start();
      chk("R3 start clears", bcd_a == 0 && bcd_b == 0 && !win_a && !win_b, bcd_a + bcd_b, 0);
      run(2, 5, 100);
      chk("R4 a wins", win_a && !win_b && bcd_a == 8, {win_a, win_b}, 2);
      chk("R5 loser below 8", bcd_b < 8, bcd_b, 7);
      hold_b = bcd_b;
      run(1 + 1, 2, 60);
      chk("R5 frozen b", bcd_b == hold_b, bcd_b, hold_b);
      chk("R5 frozen a", bcd_a == 8 && win_a, bcd_a, 8);

      // R4: B faster
      pulse_start();
      run(6, 3, 120);
      chk("R4 b wins", win_b && !win_a && bcd_b == 8, {win_a, win_b}, 1);

      // R6: tie with identical in-phase inputs
      fa = 0; fb = 0;
      run(1000, 1000, 6);
      pulse_start();
      run(3, 3, 80);
      chk("R6 tie flags", win_a && win_b, {win_a, win_b}, 3);
      chk("R6 tie counts", bcd_a == 8 && bcd_b == 8, bcd_a * 16 + bcd_b, 136);

      // R7: restart mid-race
      pulse_start();
      run(4, 4, 20);
      chk("R7 mid-race progress", bcd_a > 0 && !win_a, bcd_a, 1);
      pulse_start();
      chk("R7 restart zero", bcd_a == 0 && bcd_b == 0, bcd_a + bcd_b, 0);
      run(4, 7, 140);
      chk("R7 new race result", win_a && !win_b, {win_a, win_b}, 2);

      // R3: start during toggling ignores coincident edges
      run(2, 2, 3);
      pulse_start();
      chk("R3 start under toggling", bcd_a == 0 && bcd_b == 0, bcd_a + bcd_b, 0);
      run(2, 2, 60);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule